// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of a DMA-style Ethernet master. Software hands the engine free buffers by writing their byte offsets within a receive memory window into a small queue. When a frame arrives on the byte-stream input, the engine takes the oldest free buffer. It stores the frame bytes after a 24-byte header, then fills in the header's length field, and finally sets a "received" flag in the header's status word. Software polls that flag, consumes the frame, clears the flag and posts the buffer again.

Each buffer starts with a header. The engine writes two fields of it: the status word at byte +4 (bit 0 is the received flag) and a 16-bit length field at byte +8. The length holds a 12-bit count. The next-pointer word at +0, the port half-word at +10 and the timestamp area are left to software and never written. Frame bytes start at byte +24, and at most `PAY_BYTES` of them are stored.

The engine also keeps event counters for software. Five of them are 8-bit and saturate: oversize frames, receive errors, FCS errors, link losses and dropped frames. The sixth is a 32-bit count of delivered frames. Writing zero to a counter's clear offset resets it.

Top module: `rxr_engine`

## Requirements
- R1: A register write to offset 0x10 with bit 31 set queues the low `AW` bits as a free buffer offset. A write there with bit 31 clear is ignored. Buffers are used strictly in the order they were posted.
- R2: Frame byte i (counting from 0, FCS included) is written to buffer offset + 24 + i. The memory port is 32 bits wide, and byte address a travels on lane a mod 4.
- R3: The 16-bit field at buffer offset + 8 (little endian) receives 24 plus the number of stored bytes. This is a 12-bit value with the upper 4 bits zero. Only byte enables 0 and 1 are used, so bytes +10 and +11 are never written.
- R4: After the last data write, the length write follows, and then a write of value 1 to the status word at buffer offset + 4. The status write is always last, and it is issued two cycles after the final data write. The delivered-frame counter increments with it.
- R5: A frame whose first beat arrives while the free queue is empty is discarded whole. No memory write is made for it, and the dropped counter increments by 1.
- R6: Any write to offset 0x18 empties the free queue, whatever the data.
- R7: Bytes beyond `PAY_BYTES` are not written. Such a frame still completes with length 24 + `PAY_BYTES`, and the oversize counter increments by 1.
- R8: The FCS-error counter increments for a frame whose last beat carries `s_fcs_err`. The receive-error counter increments for a frame whose last beat carries `s_rx_err`. Both count stored and discarded frames alike, and a stored frame is still delivered.
- R9: Every high-to-low transition of `link_up` increments the link-loss counter.
- R10: The five 8-bit counters stop at 255 and do not wrap. The 32-bit delivered-frame counter wraps.
- R11: Writing zero clears a counter. The offsets are 0x40 oversize, 0x41 receive error, 0x42 FCS error, 0x43 link loss, 0x44 delivered frames and 0x45 dropped. A non-zero write to these offsets is ignored. A clear wins over an increment in the same cycle.
- R12: After reset, all counters read zero, `mem_we` is low and the free queue is empty. The stream must stay idle for at least two cycles after a last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register byte offset |
| reg_wr_data | input | 32 | Register write data |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of frame (FCS included) |
| s_fcs_err | input | 1 | FCS check failed, sampled with the last beat |
| s_rx_err | input | 1 | Receive error seen, sampled with the last beat |
| link_up | input | 1 | Link status |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Byte address in the receive window, 4-byte aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| cnt_frame_err | output | 8 | Oversize frames |
| cnt_rx_err | output | 8 | Receive errors |
| cnt_crc_err | output | 8 | FCS errors |
| cnt_link_lost | output | 8 | Link losses |
| cnt_rx_frames | output | 32 | Delivered frames |
| cnt_dropped | output | 8 | Frames discarded for lack of a buffer |

## Verification
The main receive path is driven with random frame lengths from 1 to 120 bytes, so every byte-lane position of the final partial word is covered. Random error flags on the last beat separate the delivery path from the error-count path.

Several frames are sent while the queue is empty: one right after reset, one after an invalid post and one after a flush. These show whether the queue logic really rejects entries or only appears to.

An oversize frame checks payload truncation and the clamped length together. A long run of one-byte dropped frames drives a counter into saturation. A clear issued in the same cycle as a link fall shows which of the two takes priority.

// File: rtl/rxr_pkg.sv
// Package: shared constants and types for the receive descriptor ring engine.
// Assumes byte offsets for registers and a 24-byte buffer header.
package rxr_pkg;
    localparam int HDR_BYTES   = 24;
    localparam int STAT_OFS    = 4;
    localparam int LEN_OFS     = 8;
    localparam int LEN_BITS    = 12;

    localparam logic [7:0] REG_POST  = 8'h10;
    localparam logic [7:0] REG_FLUSH = 8'h18;
    localparam logic [7:0] REG_CLR_RXF = 8'h44;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RECV, ST_DROP, ST_LEN, ST_STAT
    } rx_state_t;

    typedef enum logic [1:0] {
        WK_NONE, WK_DATA, WK_LEN, WK_STAT
    } wr_kind_t;

    // Clear offset of the i-th saturating counter (0 oversize .. 4 dropped).
    function automatic logic [7:0] clr_ofs8(input int idx);
        return (idx == 4) ? 8'h45 : 8'(8'h40 + idx);
    endfunction
endpackage

// File: rtl/rxr_free_fifo.sv
// Module: queue of free buffer offsets.
// Assumes DEPTH is a power of two. A push while full is dropped, a pop while
// empty never happens (the writer checks empty), and flush takes priority.
module rxr_free_fifo #(
    parameter int DEPTH = 16,
    parameter int AW    = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          flush,
    input  logic          pop,
    output logic [AW-1:0] head,
    output logic          empty
);
    localparam int PW = $clog2(DEPTH);

    logic [AW-1:0] slots [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [PW:0]   level;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign do_push = push && (level != (PW+1)'(DEPTH)) && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = slots[rd_ptr];

    // Stores a posted offset in the next free slot.
    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= push_addr;
    end

    // Keeps the pointers and level, with flush clearing both.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            level <= level + (PW+1)'(do_push) - (PW+1)'(do_pop);
        end
    end

    a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/rxr_sat_cnt.sv
// Module: event counter with synchronous clear.
// Saturates at all-ones when SATURATE is 1, otherwise wraps. Clear beats increment.
module rxr_sat_cnt #(
    parameter int W        = 8,
    parameter bit SATURATE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    generate
        if (SATURATE) begin : g_sat
            // Counts up to all-ones and holds there.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)           value <= '0;
                else if (inc && value != '1) value <= value + 1'b1;
            end
            a_r10_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
                (value == '1 && !clr) |=> value == '1);
        end else begin : g_wrap
            // Counts and wraps at the top.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) value <= '0;
                else if (inc)      value <= value + 1'b1;
            end
        end
    endgenerate

    a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> value == '0);
endmodule

// File: rtl/rxr_frame_writer.sv
// Module: per-frame state machine that writes bytes into a claimed buffer,
// then the length field, then the status flag.
// Assumes 4-byte aligned buffer offsets, PAY_BYTES a multiple of 4, and at
// least two idle stream cycles after each last beat.
module rxr_frame_writer
    import rxr_pkg::*;
#(
    parameter int AW        = 24,
    parameter int PAY_BYTES = 2024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    input  logic [7:0]    s_data,
    input  logic          s_last,
    input  logic          fifo_empty,
    input  logic [AW-1:0] fifo_head,
    output logic          pop,
    output logic          drop_pulse,
    output logic          ferr_pulse,
    output logic          frame_done,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be
);
    localparam int CW = $clog2(PAY_BYTES + 1);

    rx_state_t     state;
    wr_kind_t      kind;
    logic [AW-1:0] base;
    logic [CW-1:0] cnt;
    logic          ovf;
    logic [31:0]   wbuf;
    logic [3:0]    wbe;

    logic          idle, accept, in_room, last_lane, ovf_eff;
    logic [CW-1:0] k;
    logic [1:0]    lane;
    logic [AW-1:0] cur_base, word_addr;
    logic [31:0]   mbuf;
    logic [3:0]    mbe;

    initial begin
        if ((PAY_BYTES % 4) != 0 || HDR_BYTES + PAY_BYTES >= (1 << LEN_BITS))
            $error("rxr_frame_writer: PAY_BYTES unsuitable");
    end

    assign idle       = (state == ST_IDLE);
    assign accept     = s_valid && ((idle && !fifo_empty) || state == ST_RECV);
    assign pop        = s_valid && idle && !fifo_empty;
    assign drop_pulse = s_valid && idle && fifo_empty;
    assign k          = idle ? '0 : cnt;
    assign lane       = k[1:0];
    assign in_room    = (k < CW'(PAY_BYTES));
    assign ovf_eff    = idle ? 1'b0 : ovf;
    assign ferr_pulse = accept && s_last && (ovf_eff || !in_room);
    assign last_lane  = (lane == 2'd3) || s_last;
    assign cur_base   = idle ? fifo_head : base;
    assign word_addr  = cur_base + AW'(HDR_BYTES) + AW'({k[CW-1:2], 2'b00});

    // Merges the incoming byte into the partly filled word.
    always_comb begin
        mbuf = idle ? '0 : wbuf;
        mbe  = idle ? '0 : wbe;
        mbuf[{lane, 3'b000} +: 8] = s_data;
        mbe[lane] = 1'b1;
    end

    // Walks the frame phases and issues registered memory writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            kind       <= WK_NONE;
            base       <= '0;
            cnt        <= '0;
            ovf        <= 1'b0;
            wbuf       <= '0;
            wbe        <= '0;
            frame_done <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            mem_be     <= '0;
        end else begin
            mem_we     <= 1'b0;
            kind       <= WK_NONE;
            frame_done <= 1'b0;
            case (state)
                ST_IDLE: if (s_valid) begin
                    if (!fifo_empty) begin
                        base  <= fifo_head;
                        state <= s_last ? ST_LEN : ST_RECV;
                    end else begin
                        state <= s_last ? ST_IDLE : ST_DROP;
                    end
                end
                ST_RECV: if (s_valid && s_last) state <= ST_LEN;
                ST_DROP: if (s_valid && s_last) state <= ST_IDLE;
                ST_LEN: begin
                    mem_we    <= 1'b1;
                    kind      <= WK_LEN;
                    mem_addr  <= base + AW'(LEN_OFS);
                    mem_wdata <= {20'h0, LEN_BITS'(HDR_BYTES) + LEN_BITS'(cnt)};
                    mem_be    <= 4'b0011;
                    state     <= ST_STAT;
                end
                ST_STAT: begin
                    mem_we     <= 1'b1;
                    kind       <= WK_STAT;
                    mem_addr   <= base + AW'(STAT_OFS);
                    mem_wdata  <= 32'h1;
                    mem_be     <= 4'b1111;
                    frame_done <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
            if (accept) begin
                cnt <= in_room ? k + 1'b1 : k;
                ovf <= ovf_eff || !in_room;
                if (in_room) begin
                    if (last_lane) begin
                        mem_we    <= 1'b1;
                        kind      <= WK_DATA;
                        mem_addr  <= word_addr;
                        mem_wdata <= mbuf;
                        mem_be    <= mbe;
                        wbuf      <= '0;
                        wbe       <= '0;
                    end else begin
                        wbuf <= mbuf;
                        wbe  <= mbe;
                    end
                end
            end
        end
    end

    a_r4_stat_after_len: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && kind == WK_STAT) |-> $past(mem_we && kind == WK_LEN));
    a_r2_data_in_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && kind == WK_DATA) |->
            (mem_addr >= base + AW'(HDR_BYTES) &&
             mem_addr <  base + AW'(HDR_BYTES + PAY_BYTES)));
    a_r12_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEN || state == ST_STAT) |-> !s_valid);
endmodule

// File: rtl/rxr_engine.sv
// Module: top of the receive descriptor ring engine. Decodes register writes,
// hosts the free queue, the frame writer and the event counters.
// Assumes register writes and stream beats share one clock domain.
module rxr_engine
    import rxr_pkg::*;
#(
    parameter int AW         = 24,
    parameter int FIFO_DEPTH = 16,
    parameter int PAY_BYTES  = 2024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [7:0]    reg_wr_addr,
    input  logic [31:0]   reg_wr_data,
    input  logic          s_valid,
    input  logic [7:0]    s_data,
    input  logic          s_last,
    input  logic          s_fcs_err,
    input  logic          s_rx_err,
    input  logic          link_up,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [3:0]    mem_be,
    output logic [7:0]    cnt_frame_err,
    output logic [7:0]    cnt_rx_err,
    output logic [7:0]    cnt_crc_err,
    output logic [7:0]    cnt_link_lost,
    output logic [31:0]   cnt_rx_frames,
    output logic [7:0]    cnt_dropped
);
    localparam int NSAT = 5;

    logic          push, flush, pop, fifo_empty;
    logic [AW-1:0] fifo_head;
    logic          drop_pulse, ferr_pulse, frame_done;
    logic          link_q, link_fall;
    logic          wr_zero;
    logic [NSAT-1:0] inc8, clr8;
    logic [7:0]      val8 [NSAT];

    assign push    = reg_wr_en && reg_wr_addr == REG_POST && reg_wr_data[31];
    assign flush   = reg_wr_en && reg_wr_addr == REG_FLUSH;
    assign wr_zero = reg_wr_en && (reg_wr_data == 32'h0);

    // Remembers the previous link state to find falls.
    always_ff @(posedge clk) begin
        if (!rst_n) link_q <= 1'b0;
        else        link_q <= link_up;
    end
    assign link_fall = link_q && !link_up;

    rxr_free_fifo #(.DEPTH(FIFO_DEPTH), .AW(AW)) free_q (
        .clk(clk), .rst_n(rst_n), .push(push), .push_addr(reg_wr_data[AW-1:0]),
        .flush(flush), .pop(pop), .head(fifo_head), .empty(fifo_empty)
    );

    rxr_frame_writer #(.AW(AW), .PAY_BYTES(PAY_BYTES)) writer (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
        .s_last(s_last), .fifo_empty(fifo_empty), .fifo_head(fifo_head),
        .pop(pop), .drop_pulse(drop_pulse), .ferr_pulse(ferr_pulse),
        .frame_done(frame_done), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be)
    );

    assign inc8[0] = ferr_pulse;
    assign inc8[1] = s_valid && s_last && s_rx_err;
    assign inc8[2] = s_valid && s_last && s_fcs_err;
    assign inc8[3] = link_fall;
    assign inc8[4] = drop_pulse;

    generate
        for (genvar i = 0; i < NSAT; i++) begin : g_cnt8
            assign clr8[i] = wr_zero && reg_wr_addr == clr_ofs8(i);
            rxr_sat_cnt #(.W(8), .SATURATE(1'b1)) u_cnt (
                .clk(clk), .rst_n(rst_n), .clr(clr8[i]), .inc(inc8[i]),
                .value(val8[i])
            );
        end
    endgenerate

    rxr_sat_cnt #(.W(32), .SATURATE(1'b0)) u_rxf (
        .clk(clk), .rst_n(rst_n), .clr(wr_zero && reg_wr_addr == REG_CLR_RXF),
        .inc(frame_done), .value(cnt_rx_frames)
    );

    assign cnt_frame_err = val8[0];
    assign cnt_rx_err    = val8[1];
    assign cnt_crc_err   = val8[2];
    assign cnt_link_lost = val8[3];
    assign cnt_dropped   = val8[4];

    a_r5_drop_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |=> !mem_we);
endmodule

// File: tb/rxr_engine_tb_top.sv
module rxr_engine_tb_top;
    localparam int PAY  = 2024;
    localparam int HDR  = 24;
    localparam int SLOT = 32'h800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic        s_valid = 1'b0, s_last = 1'b0, s_fcs_err = 1'b0, s_rx_err = 1'b0;
    logic [7:0]  s_data = '0;
    logic        link_up = 1'b1;
    logic        mem_we;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic [7:0]  cnt_frame_err, cnt_rx_err, cnt_crc_err, cnt_link_lost, cnt_dropped;
    logic [31:0] cnt_rx_frames;

    rxr_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .s_valid(s_valid), .s_data(s_data),
        .s_last(s_last), .s_fcs_err(s_fcs_err), .s_rx_err(s_rx_err),
        .link_up(link_up), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .cnt_frame_err(cnt_frame_err),
        .cnt_rx_err(cnt_rx_err), .cnt_crc_err(cnt_crc_err),
        .cnt_link_lost(cnt_link_lost), .cnt_rx_frames(cnt_rx_frames),
        .cnt_dropped(cnt_dropped)
    );

    always #4 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    logic [7:0] mem [int];
    logic [7:0] fb [];
    int cur_base = -1;
    int wr_count = 0, stat_seen = 0;
    bit len_seen = 0, stat_ok = 0;
    int exp_q [$];
    int e_ferr = 0, e_rxe = 0, e_crc = 0, e_lnk = 0, e_drp = 0;
    longint e_rxf = 0;

    function automatic int sat8(input int v);
        return (v >= 255) ? 255 : v + 1;
    endfunction

    function automatic int stored_of(input int n);
        return (n > PAY) ? PAY : n;
    endfunction

    function automatic logic [7:0] rdb(input int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Memory model: applies each write away from the clock edge.
    always @(negedge clk) begin
        if (mem_we) begin
            wr_count++;
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[int'(mem_addr) + b] = mem_wdata[8*b +: 8];
            if (int'(mem_addr) == cur_base + 8 && mem_be == 4'b0011) len_seen = 1;
            if (int'(mem_addr) == cur_base + 4 && mem_be == 4'hF) begin
                stat_seen++;
                stat_ok = len_seen;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic post(input int off);
        for (int i = 0; i < SLOT; i++) mem.delete(off + i);
        reg_wr(8'h10, 32'h8000_0000 | off);
        exp_q.push_back(off);
    endtask

    task automatic send_frame(input int n, input bit fcs, input bit rxe, input int base);
        fb = new[n];
        foreach (fb[i]) fb[i] = 8'($urandom);
        cur_base = base; len_seen = 0; stat_seen = 0; stat_ok = 0; wr_count = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            s_valid = 1'b1; s_data = fb[i]; s_last = (i == n - 1);
            s_fcs_err = fcs && (i == n - 1); s_rx_err = rxe && (i == n - 1);
        end
        @(posedge clk); #1;
        s_valid = 1'b0; s_last = 1'b0; s_fcs_err = 1'b0; s_rx_err = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        if (fcs) e_crc = sat8(e_crc);
        if (rxe) e_rxe = sat8(e_rxe);
        if (base < 0) e_drp = sat8(e_drp);
        else begin
            e_rxf++;
            if (n > PAY) e_ferr = sat8(e_ferr);
        end
    endtask

    task automatic check_frame(input int off, input int n);
        int st, errs;
        st = stored_of(n);
        errs = 0;
        for (int i = 0; i < st; i++)
            if (!mem.exists(off + HDR + i) || mem[off + HDR + i] != fb[i]) errs++;
        chk(errs == 0, "R2 payload bytes mismatched", errs, 0);
        chk({rdb(off + 9), rdb(off + 8)} == 16'(HDR + st), "R3 length field",
            {rdb(off + 9), rdb(off + 8)}, HDR + st);
        chk(!mem.exists(off + 10) && !mem.exists(off + 11), "R3 port half written",
            mem.exists(off + 10), 0);
        chk(rdb(off + 4) == 8'h01 && stat_seen == 1 && stat_ok, "R4 status last",
            {rdb(off + 4), 8'(stat_seen), 7'h0, stat_ok}, 32'h0101_0001);
    endtask

    task automatic check_counters(input string req);
        chk(cnt_frame_err == 8'(e_ferr) && cnt_rx_err == 8'(e_rxe) &&
            cnt_crc_err == 8'(e_crc) && cnt_link_lost == 8'(e_lnk) &&
            cnt_dropped == 8'(e_drp) && cnt_rx_frames == 32'(e_rxf), req,
            {cnt_frame_err, cnt_rx_err, cnt_crc_err, cnt_link_lost, cnt_dropped},
            {8'(e_ferr), 8'(e_rxe), 8'(e_crc), 8'(e_lnk), 8'(e_drp)});
    endtask

    initial begin
        int n, off, slot;
        bit fcs, rxe;
        void'($urandom(32'h5EED_0001));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(!mem_we && cnt_rx_frames == 0 && cnt_dropped == 0 && cnt_crc_err == 0,
            "R12 reset state", {mem_we, cnt_rx_frames}, 0);
        // R12 + R5: queue empty after reset, frame is dropped with no writes
        send_frame(10, 1'b0, 1'b0, -1);
        chk(wr_count == 0, "R5 write during drop after reset", wr_count, 0);
        check_counters("R5 R12 drop counted");

        // R1: post without valid bit is ignored
        reg_wr(8'h10, 32'h0000_0800);
        send_frame(6, 1'b0, 1'b0, -1);
        chk(wr_count == 0 && cnt_dropped == 8'(e_drp), "R1 invalid post ignored",
            wr_count, 0);

        // R1 R2 R3 R4 R8: random frames, buffers used in post order
        slot = 0;
        repeat (3) begin post(slot * SLOT); slot = (slot + 1) % 8; end
        for (int f = 0; f < 30; f++) begin
            n = 1 + ($urandom % 120);
            fcs = (($urandom % 4) == 0);
            rxe = (($urandom % 4) == 0);
            off = exp_q.pop_front();
            send_frame(n, fcs, rxe, off);
            check_frame(off, n);
            check_counters("R8 R4 counters after frame");
            post(slot * SLOT); slot = (slot + 1) % 8;
        end

        // R6: flush empties the queue
        reg_wr(8'h18, 32'h1234_5678);
        exp_q.delete();
        send_frame(5, 1'b0, 1'b0, -1);
        chk(wr_count == 0, "R6 write after flush", wr_count, 0);
        check_counters("R6 drop after flush");

        // R7: oversize frame is truncated
        post(3 * SLOT);
        off = exp_q.pop_front();
        send_frame(PAY + 6, 1'b0, 1'b0, off);
        check_frame(off, PAY + 6);
        chk(!mem.exists(off + HDR + PAY), "R7 byte beyond payload written",
            mem.exists(off + HDR + PAY), 0);
        chk(cnt_frame_err == 8'(e_ferr) && e_ferr == 1, "R7 oversize count",
            cnt_frame_err, e_ferr);

        // R9: three link falls
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1 link_up = 1'b0;
            repeat (2) @(posedge clk);
            #1 link_up = 1'b1;
            repeat (2) @(posedge clk);
            e_lnk = sat8(e_lnk);
        end
        #2;
        chk(cnt_link_lost == 8'd3, "R9 link loss count", cnt_link_lost, 3);

        // R10: dropped counter saturates
        for (int i = 0; i < 260; i++) send_frame(1, 1'b0, 1'b0, -1);
        chk(cnt_dropped == 8'd255, "R10 saturation", cnt_dropped, 255);
        check_counters("R10 all counters");

        // R11: non-zero write ignored, zero write clears
        reg_wr(8'h45, 32'h0000_0001);
        #2;
        chk(cnt_dropped == 8'd255, "R11 nonzero clear ignored", cnt_dropped, 255);
        reg_wr(8'h45, 32'h0);
        #2;
        chk(cnt_dropped == 8'd0, "R11 zero write clears", cnt_dropped, 0);
        reg_wr(8'h44, 32'h0);
        #2;
        chk(cnt_rx_frames == 32'd0, "R11 frame counter clear", cnt_rx_frames, 0);
        // R11: clear wins over a same-cycle link fall
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_wr_addr = 8'h43; reg_wr_data = 32'h0; link_up = 1'b0;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
        @(negedge clk);
        chk(cnt_link_lost == 8'd0, "R11 clear beats increment", cnt_link_lost, 0);
        link_up = 1'b1;
        repeat (2) @(posedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule